// File: doc/BRIEF.md
# Fractional-N Divide Ratio Controller

This block sits in the feedback path of a frequency synthesizer. It divides a fast clock by an integer that changes from one division to the next, so that the long-run average ratio is N + F/M. N is the integer part, F is the fraction numerator and M is the modulus. Every single division lasts either N or N+1 clock cycles. A first-order accumulator decides which of the two each division uses, so that over time the average settles on the fractional value.

The block runs entirely in the divided clock domain. At the end of each division it does three things. It adds F into an accumulator that wraps at M. If the sum reaches M, it subtracts M and makes the next division one cycle longer. It then restarts its variable-length counter. The block emits one pulse, one clock wide, at the end of every division. N, F and M are plain control inputs. The block samples them only at division boundaries, so software may rewrite them at any time. There is no streaming data path, so the block has no valid/ready handshake and no back-pressure.

Top module: `frac_div_ctrl`

## Requirements
- R1: Each division lasts either Ne or Ne+1 cycles, where Ne is the effective integer part (see R8). At each boundary the block forms S = acc + Fe. If M is non-zero and S >= M, then acc becomes S - M and the next division uses Ne+1. Otherwise acc becomes S and the next division uses Ne.
- R2: While N, F and M are held constant with 0 < F < M, any M consecutive divisions contain exactly F divisions of length Ne+1.
- R3: With F = 0, every division lasts exactly Ne cycles.
- R4: When F >= M at a boundary (this includes M = 0), the block treats the fraction as 0. It also drives `cfg_err_o` high from the cycle after that boundary until the next boundary. A valid setting clears the flag at the next boundary.
- R5: The block samples `int_ratio_i`, `frac_num_i` and `modulus_i` only at division boundaries. Changes that come and go within a division have no effect on that division's length.
- R6: When M at a boundary differs from the M used before, the accumulator restarts at 0 and the next division uses Ne, with no carry.
- R7: `div_pulse_o` is high for exactly one cycle, in the last cycle of each division. The number of cycles between successive pulses equals that division's length.
- R8: Ne is `int_ratio_i`, raised to 2 when the input is below 2.
- R9: During reset `div_pulse_o` and `cfg_err_o` are low. The first edge after reset releases is a boundary with an accumulator of 0 and a previous modulus of 0. The first pulse comes Ne cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| int_ratio_i | input | NW | Integer part N of the ratio |
| frac_num_i | input | MW | Fraction numerator F |
| modulus_i | input | MW | Fraction modulus M |
| div_pulse_o | output | 1 | One-cycle pulse at the end of each division |
| cfg_err_o | output | 1 | High while the latched fraction was invalid (F >= M) |

## Verification
The bound checker verifies on every cycle that:
- the output pulse is one clock wide and the counter restarts right after it;
- the accumulator stays below the latched modulus;
- the active ratio never drops below 2 and changes only at a boundary;
- the error flag follows the F >= M test made at each boundary.

Some behaviours span many cycles and only the bench scenarios can show them:
- the exact length of each division against an independent accumulator model;
- exactly F long divisions in every window of M;
- the accumulator restart when M changes;
- immunity to input changes that come and go within a division.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int MIN_RATIO = 2;

  typedef enum logic {
    PH_BOOT = 1'b0,
    PH_RUN  = 1'b1
  } div_phase_t;
endpackage

// File: rtl/frac_cfg_sanitize.sv
module frac_cfg_sanitize #(
  parameter int NW = 12,
  parameter int MW = 8
) (
  input  logic [NW-1:0] n_in,
  input  logic [MW-1:0] f_in,
  input  logic [MW-1:0] m_in,
  output logic [NW-1:0] n_eff,
  output logic [MW-1:0] f_eff,
  output logic          bad
);
  import frac_div_pkg::*;

  localparam logic [NW-1:0] NFLOOR = NW'(MIN_RATIO);

  always_comb begin
    bad   = (f_in >= m_in);
    f_eff = bad ? '0 : f_in;
    n_eff = (n_in < NFLOOR) ? NFLOOR : n_in;
  end
endmodule

// File: rtl/frac_accum.sv
module frac_accum #(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [MW-1:0] f_eff,
  input  logic [MW-1:0] m_in,
  output logic          carry,
  output logic [MW-1:0] acc_q,
  output logic [MW-1:0] mod_q
);
  logic          mod_change;
  logic [MW:0]   sum;
  logic [MW:0]   wrapped;
  logic [MW-1:0] acc_next;

  always_comb begin
    mod_change = (m_in != mod_q);
    sum        = {1'b0, acc_q} + {1'b0, f_eff};
    wrapped    = sum - {1'b0, m_in};
    carry      = !mod_change && (m_in != '0) && (sum >= {1'b0, m_in});
    if (mod_change)
      acc_next = '0;
    else if (carry)
      acc_next = wrapped[MW-1:0];
    else
      acc_next = sum[MW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      mod_q <= '0;
    end else if (step) begin
      acc_q <= acc_next;
      mod_q <= m_in;
    end
  end
endmodule

// File: rtl/vmod_counter.sv
module vmod_counter #(
  parameter int RW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] next_ratio,
  output logic          load,
  output logic          pulse,
  output logic [RW-1:0] cnt_q,
  output logic [RW-1:0] ratio_q
);
  import frac_div_pkg::*;

  div_phase_t phase_q;

  always_comb begin
    pulse = (phase_q == PH_RUN) && (cnt_q == ratio_q - 1'b1);
    load  = (phase_q == PH_BOOT) || pulse;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_BOOT;
      cnt_q   <= '0;
      ratio_q <= RW'(MIN_RATIO);
    end else if (load) begin
      phase_q <= PH_RUN;
      cnt_q   <= '0;
      ratio_q <= next_ratio;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/frac_div_ctrl.sv
module frac_div_ctrl #(
  parameter int NW = 12,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] int_ratio_i,
  input  logic [MW-1:0] frac_num_i,
  input  logic [MW-1:0] modulus_i,
  output logic          div_pulse_o,
  output logic          cfg_err_o
);
  localparam int RW = NW + 1;

  logic [NW-1:0] n_eff;
  logic [MW-1:0] f_eff;
  logic          cfg_bad;
  logic          carry;
  logic [MW-1:0] acc_w;
  logic [MW-1:0] mod_w;
  logic          load_w;
  logic          pulse_w;
  logic [RW-1:0] cnt_w;
  logic [RW-1:0] ratio_w;
  logic [RW-1:0] next_ratio;
  logic          err_q;

  frac_cfg_sanitize #(.NW(NW), .MW(MW)) u_cfg (
    .n_in  (int_ratio_i),
    .f_in  (frac_num_i),
    .m_in  (modulus_i),
    .n_eff (n_eff),
    .f_eff (f_eff),
    .bad   (cfg_bad)
  );

  frac_accum #(.MW(MW)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (load_w),
    .f_eff (f_eff),
    .m_in  (modulus_i),
    .carry (carry),
    .acc_q (acc_w),
    .mod_q (mod_w)
  );

  assign next_ratio = RW'(n_eff) + RW'(carry);

  vmod_counter #(.RW(RW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .next_ratio (next_ratio),
    .load       (load_w),
    .pulse      (pulse_w),
    .cnt_q      (cnt_w),
    .ratio_q    (ratio_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      err_q <= 1'b0;
    else if (load_w)
      err_q <= cfg_bad;
  end

  assign div_pulse_o = pulse_w;
  assign cfg_err_o   = err_q;
endmodule

// File: rtl/frac_div_chk.sv
module frac_div_chk #(
  parameter int RW = 13,
  parameter int MW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pulse,
  input logic          load,
  input logic [RW-1:0] cnt,
  input logic [RW-1:0] ratio,
  input logic [MW-1:0] acc,
  input logic [MW-1:0] mod_q,
  input logic [MW-1:0] frac_in,
  input logic [MW-1:0] mod_in,
  input logic          err
);
  // R7: pulse is a single cycle wide
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  // R7: a new division starts counting from zero after each pulse
  a_r7_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> (cnt == '0));

  // R1: accumulator stays below the modulus it was built with
  a_r1_acc_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_q != '0) |-> (acc < mod_q));

  // R8: active ratio never falls below the floor of two
  a_r8_ratio_floor: assert property (@(posedge clk) disable iff (!rst_n)
    ratio >= RW'(2));

  // R5: ratio only changes on a boundary
  a_r5_ratio_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ratio));

  // R4: error flag reflects the fraction check made at the boundary
  a_r4_err_follow: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (err == $past(frac_in >= mod_in)));
endmodule

bind frac_div_ctrl frac_div_chk #(.RW(RW), .MW(MW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pulse   (pulse_w),
  .load    (load_w),
  .cnt     (cnt_w),
  .ratio   (ratio_w),
  .acc     (acc_w),
  .mod_q   (mod_w),
  .frac_in (frac_num_i),
  .mod_in  (modulus_i),
  .err     (err_q)
);

// File: tb/frac_div_ctrl_test.sv
module frac_div_ctrl_test;
  localparam int NW = 12;
  localparam int MW = 8;
  localparam int NV = 9;
  localparam int V_N [NV] = '{10, 4, 6, 5, 3, 1, 12, 7, 9};
  localparam int V_F [NV] = '{ 1, 0, 3, 7, 5, 1,  2, 0, 2};
  localparam int V_M [NV] = '{ 5, 7, 8, 7, 4, 2,  3, 0, 3};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NW-1:0] n_drv = '0;
  logic [MW-1:0] f_drv = '0;
  logic [MW-1:0] m_drv = '0;
  logic          pulse;
  logic          err;

  int nchk = 0;
  int nfail = 0;
  int acc_m = 0;
  int mprev = 0;
  int exp_len = 0;
  int exp_base = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  frac_div_ctrl #(.NW(NW), .MW(MW)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_ratio_i (n_drv),
    .frac_num_i  (f_drv),
    .modulus_i   (m_drv),
    .div_pulse_o (pulse),
    .cfg_err_o   (err)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Model of one boundary, from the requirements, using the current inputs
  task automatic predict();
    int ne, fe, m, s, c;
    m  = int'(m_drv);
    ne = (int'(n_drv) < 2) ? 2 : int'(n_drv);
    fe = (int'(f_drv) < m) ? int'(f_drv) : 0;
    c  = 0;
    if (m != mprev) begin
      acc_m = 0;
    end else begin
      s = acc_m + fe;
      if (m != 0 && s >= m) begin
        c = 1;
        acc_m = s - m;
      end else begin
        acc_m = s;
      end
    end
    mprev    = m;
    exp_base = ne;
    exp_len  = ne + c;
  endtask

  // Wait for the next pulse, check the interval, predict the following one
  task automatic next_div(input string tag, output bit was_long);
    int len;
    do begin
      @(negedge clk);
      cyc++;
    end while (!pulse && cyc < 5000);
    len = cyc;
    check(pulse && len == exp_len, tag, len, exp_len);
    was_long = (len == exp_base + 1);
    predict();
    cyc = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    bit lg;
    n_drv = NW'(V_N[0]);
    f_drv = MW'(V_F[0]);
    m_drv = MW'(V_M[0]);
    repeat (3) @(negedge clk);
    check(!pulse, "R9 pulse low in reset", int'(pulse), 0);
    check(!err, "R9 error flag low in reset", int'(err), 0);
    rst_n = 1'b1;
    acc_m = 0;
    mprev = 0;
    predict();
    cyc = 0;
    next_div("R9 first division after reset", lg);

    for (int v = 0; v < NV; v++) begin
      int me, fe, divs, longs;
      bit bad;
      if (v > 0) begin
        @(negedge clk);
        cyc++;
        n_drv = NW'(V_N[v]);
        f_drv = MW'(V_F[v]);
        m_drv = MW'(V_M[v]);
      end
      bad   = (V_F[v] >= V_M[v]);
      fe    = bad ? 0 : V_F[v];
      me    = (V_M[v] == 0) ? 4 : V_M[v];
      divs  = 2 * me + 2;
      longs = 0;
      for (int k = 0; k < divs; k++) begin
        next_div($sformatf("vec%0d R1 R6 R7 R8 division length", v), lg);
        if (k == 1)
          check(err == bad, $sformatf("vec%0d R4 error flag", v), int'(err), int'(bad));
        if (k >= divs - me && lg)
          longs++;
      end
      if (V_M[v] != 0)
        check(longs == fe, $sformatf("vec%0d R2 R3 long divisions per window", v), longs, fe);
    end

    // R5: a glitch inside a division must not alter it
    @(negedge clk);
    cyc++;
    n_drv = NW'(20);
    f_drv = MW'(0);
    m_drv = MW'(3);
    next_div("R5 setup division", lg);
    repeat (3) begin @(negedge clk); cyc++; end
    n_drv = NW'(2);
    f_drv = MW'(8);
    m_drv = MW'(9);
    repeat (5) begin @(negedge clk); cyc++; end
    n_drv = NW'(20);
    f_drv = MW'(0);
    m_drv = MW'(3);
    check(!err, "R5 flag unchanged mid-division", int'(err), 0);
    next_div("R5 glitch ignored, length", lg);
    next_div("R3 pure integer after glitch", lg);
    @(negedge clk);
    check(!pulse, "R7 pulse one cycle wide", int'(pulse), 0);

    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule